// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a single-channel 10-bit successive-approximation converter. The link has an active-low chip select, a serial clock and a return data line. Each time chip select falls, the converter starts a new conversion. The controller then produces sixteen serial clock periods from a divided system clock and collects one data bit on each rising edge. When chip select returns high, it presents the 10-bit straight-binary code together with a one-cycle valid strobe.

A frame starts for one of two reasons: a start pulse, or the expiry of a sample timer whose period is given in system clock cycles. A request that arrives while a frame or the quiet gap after it is still running is held, and it is served once the gap has passed. While the power-save input is high, chip select stays high, which keeps the converter shut down, and every request is dropped.

When power-save is released, the first result is flagged as a dummy conversion. The gap after that frame is stretched to the power-up count, so that the next result can be trusted.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is high and the valid strobe is low.
- R2: A frame holds chip select low for exactly 16 rising serial clock edges. The serial clock idles high, and its first falling edge comes HALF_DIV system cycles after chip select falls.
- R3: Each serial clock phase, both the low half and the high half, lasts HALF_DIV system cycles.
- R4: Data is taken on rising serial clock edges, first bit into the MSB of a 16-bit frame. The reported code is the 10 bits that start DATA_OFS bits after the first frame bit, MSB first (default offset 4, so frame bits 4 to 13).
- R5: The valid strobe lasts one cycle and coincides with chip select rising. The code and the dummy flag stay unchanged until the next strobe.
- R6: Between any two frames, chip select stays high for at least QUIET_CYC system cycles.
- R7: A start pulse during a frame or its quiet gap is held as a pending request. Several such pulses still give only one further frame.
- R8: While the timer is enabled and the engine is idle at each tick, chip select falls every period_i system cycles.
- R9: While power-save is high, no frame starts, and start pulses and timer ticks are discarded. They do not start a frame after power-save is released.
- R10: The first frame after power-save is released reports the dummy flag as 1, and later frames report 0. Chip select then stays high for at least PWRUP_CYC cycles before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle conversion request |
| timer_en_i | input | 1 | Enables the periodic sample timer |
| period_i | input | PERIOD_W | Timer period in system cycles |
| psave_i | input | 1 | Power-save: keep chip select high, drop requests |
| adc_cs_n_o | output | 1 | Active-low chip select to converter |
| adc_sclk_o | output | 1 | Serial clock to converter |
| adc_sdata_i | input | 1 | Serial data from converter |
| code_o | output | 10 | Last straight-binary conversion code |
| dummy_o | output | 1 | Last result was the post-wake dummy conversion |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The embedded properties watch the following on every cycle:
- the serial clock stays high whenever chip select is high;
- each frame carries exactly sixteen rising edges;
- the quiet gap never falls short;
- no frame starts while power-save is high;
- the valid strobe never lasts longer than one cycle;
- a pending request survives until it is accepted.

Some behaviours depend on the converter's data and on what happened earlier, so only the bench scenarios can show them:
- the correct code at the chosen bit offset;
- the dummy flag after a wake;
- the stretched power-up gap;
- the exact timer spacing;
- requests made during power-save being discarded rather than postponed.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int FRAME_LEN = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } eng_state_e;

    typedef struct packed {
        logic                dummy;
        logic [SAMPLE_W-1:0] code;
    } sample_t;

    // Take SAMPLE_W bits starting ofs bits after the first (MSB) frame bit.
    function automatic logic [SAMPLE_W-1:0] pick_code(
        input logic [FRAME_LEN-1:0] frame,
        input int unsigned          ofs
    );
        logic [FRAME_LEN-1:0] shifted;
        shifted = frame >> (FRAME_LEN - SAMPLE_W - ofs);
        return shifted[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/adc_req_sched.sv
module adc_req_sched #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                timer_en_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                psave_i,
    input  logic                accept_i,
    output logic                req_o,
    output logic                dummy_o
);

    logic [PERIOD_W-1:0] tcnt;
    logic                tick;
    logic                pend;
    logic                psave_q;
    logic                wake;

    always_comb tick = timer_en_i && (tcnt == period_i - PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt    <= '0;
            pend    <= 1'b0;
            psave_q <= 1'b0;
            wake    <= 1'b0;
        end else begin
            psave_q <= psave_i;
            tcnt    <= (!timer_en_i || tick) ? '0 : tcnt + PERIOD_W'(1);
            if (psave_i)
                pend <= 1'b0;
            else if (start_i || tick)
                pend <= 1'b1;
            else if (accept_i)
                pend <= 1'b0;
            if (psave_q && !psave_i)
                wake <= 1'b1;
            else if (accept_i)
                wake <= 1'b0;
        end
    end

    assign req_o   = pend && !psave_i;
    assign dummy_o = wake;

    // R7: an unserved request stays pending until the engine takes it
    p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
        (req_o && !accept_i && !psave_i) |=> pend);

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_frame_pkg::*;
#(
    parameter int HALF_DIV  = 13,
    parameter int QUIET_CYC = 13,
    parameter int PWRUP_CYC = 250,
    parameter int DATA_OFS  = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_i,
    input  logic    dummy_i,
    input  logic    sdata_i,
    output logic    accept_o,
    output logic    cs_n_o,
    output logic    sclk_o,
    output sample_t sample_o,
    output logic    valid_o
);

    localparam int WAKE_GAP = (PWRUP_CYC > QUIET_CYC) ? PWRUP_CYC : QUIET_CYC;
    localparam int HCW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int GCW      = $clog2(WAKE_GAP + 1);
    localparam int BCW      = $clog2(FRAME_LEN + 1);
    localparam int HIW      = $clog2(WAKE_GAP + 3);

    eng_state_e           state;
    logic [HCW-1:0]       hcnt;
    logic [GCW-1:0]       gcnt;
    logic [BCW-1:0]       bcnt;
    logic [FRAME_LEN-1:0] shreg;
    logic                 dummy_q;
    logic                 half_done;
    logic [GCW-1:0]       gap_lim;

    always_comb begin
        half_done = (hcnt == HCW'(HALF_DIV - 1));
        gap_lim   = dummy_q ? GCW'(WAKE_GAP - 1) : GCW'(QUIET_CYC - 1);
        accept_o  = (state == ST_IDLE) && req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cs_n_o   <= 1'b1;
            sclk_o   <= 1'b1;
            hcnt     <= '0;
            gcnt     <= '0;
            bcnt     <= '0;
            shreg    <= '0;
            dummy_q  <= 1'b0;
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                ST_IDLE: if (req_i) begin
                    cs_n_o  <= 1'b0;
                    hcnt    <= '0;
                    bcnt    <= '0;
                    dummy_q <= dummy_i;
                    state   <= ST_SETUP;
                end
                ST_SETUP: if (half_done) begin
                    sclk_o <= 1'b0;
                    hcnt   <= '0;
                    state  <= ST_LOW;
                end else hcnt <= hcnt + HCW'(1);
                ST_LOW: if (half_done) begin
                    sclk_o <= 1'b1;
                    shreg  <= {shreg[FRAME_LEN-2:0], sdata_i};
                    bcnt   <= bcnt + BCW'(1);
                    hcnt   <= '0;
                    state  <= ST_HIGH;
                end else hcnt <= hcnt + HCW'(1);
                ST_HIGH: if (half_done) begin
                    hcnt <= '0;
                    if (bcnt == BCW'(FRAME_LEN)) begin
                        cs_n_o         <= 1'b1;
                        gcnt           <= '0;
                        valid_o        <= 1'b1;
                        sample_o.dummy <= dummy_q;
                        sample_o.code  <= pick_code(shreg, DATA_OFS);
                        state          <= ST_GAP;
                    end else begin
                        sclk_o <= 1'b0;
                        state  <= ST_LOW;
                    end
                end else hcnt <= hcnt + HCW'(1);
                ST_GAP: if (gcnt >= gap_lim) state <= ST_IDLE;
                        else gcnt <= gcnt + GCW'(1);
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: cycles with chip select high, rising edges in a frame
    logic [HIW-1:0] hi_cnt;
    logic [BCW-1:0] rise_cnt;
    logic           sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= HIW'(WAKE_GAP + 2);
            rise_cnt <= '0;
            sclk_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_o;
            if (!cs_n_o)
                hi_cnt <= '0;
            else if (hi_cnt != HIW'(WAKE_GAP + 2))
                hi_cnt <= hi_cnt + HIW'(1);
            if (state == ST_IDLE)
                rise_cnt <= '0;
            else if (sclk_o && !sclk_q)
                rise_cnt <= rise_cnt + BCW'(1);
        end
    end

    p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);

    p_sixteen_edges_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> (rise_cnt == BCW'(FRAME_LEN)));

    p_quiet_gap_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> ($past(hi_cnt) >= HIW'(QUIET_CYC)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_valid_at_cs_rise_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o));

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int HALF_DIV  = 13,
    parameter int QUIET_CYC = 13,
    parameter int PWRUP_CYC = 250,
    parameter int DATA_OFS  = 4,
    parameter int PERIOD_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                timer_en_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                psave_i,
    output logic                adc_cs_n_o,
    output logic                adc_sclk_o,
    input  logic                adc_sdata_i,
    output logic [SAMPLE_W-1:0] code_o,
    output logic                dummy_o,
    output logic                valid_o
);

    logic    req;
    logic    wake_dummy;
    logic    accept;
    sample_t sample;

    adc_req_sched #(.PERIOD_W(PERIOD_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .timer_en_i (timer_en_i),
        .period_i   (period_i),
        .psave_i    (psave_i),
        .accept_i   (accept),
        .req_o      (req),
        .dummy_o    (wake_dummy)
    );

    adc_frame_engine #(
        .HALF_DIV  (HALF_DIV),
        .QUIET_CYC (QUIET_CYC),
        .PWRUP_CYC (PWRUP_CYC),
        .DATA_OFS  (DATA_OFS)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .dummy_i  (wake_dummy),
        .sdata_i  (adc_sdata_i),
        .accept_o (accept),
        .cs_n_o   (adc_cs_n_o),
        .sclk_o   (adc_sclk_o),
        .sample_o (sample),
        .valid_o  (valid_o)
    );

    assign code_o  = sample.code;
    assign dummy_o = sample.dummy;

    // R9: chip select never falls on a request seen under power-save
    p_no_frame_in_psave_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n_o) |-> !$past(psave_i));

endmodule

// File: tb/test_adc_frame_ctrl.sv
`timescale 1ns/1ps
module test_adc_frame_ctrl;

    localparam int HALF  = 13;
    localparam int QUIET = 13;
    localparam int PWRUP = 250;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        timer_en_i = 1'b0;
    logic [15:0] period_i = 16'd600;
    logic        psave_i = 1'b0;
    logic        adc_cs_n_o, adc_sclk_o;
    logic        adc_sdata_i = 1'b0;
    logic [9:0]  code_o;
    logic        dummy_o, valid_o;

    always #2 clk = ~clk;

    adc_frame_ctrl i_adc_frame_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .timer_en_i(timer_en_i),
        .period_i(period_i), .psave_i(psave_i), .adc_cs_n_o(adc_cs_n_o),
        .adc_sclk_o(adc_sclk_o), .adc_sdata_i(adc_sdata_i), .code_o(code_o),
        .dummy_o(dummy_o), .valid_o(valid_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct { bit dum; bit [9:0] code; } exp_t;
    exp_t      exp_q[$];
    bit [9:0]  code_q[$];

    // Driver side: queue the code the converter returns and the expected result
    task automatic load(input bit [9:0] code, input bit dum);
        exp_t e;
        e.dum = dum;
        e.code = code;
        code_q.push_back(code);
        exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Converter model: frame = 4 leading zeros, 10 code bits, 2 trailing zeros
    bit [15:0] cur_frame = '0;
    int        bitn = 0;
    always @(negedge adc_cs_n_o) if (!rst) begin
        cur_frame = (code_q.size() > 0) ? {4'b0000, code_q.pop_front(), 2'b00} : 16'h0;
        bitn = 0;
    end
    always @(negedge adc_sclk_o) if (!adc_cs_n_o && bitn < 16) begin
        adc_sdata_i = cur_frame[15 - bitn];
        bitn++;
    end

    // Monitor: timing of the serial link and scoreboard comparison
    int  cyc = 0, nframes = 0, nfalls = 0, rises = 0;
    int  hi_cnt = 0, fall_cyc = 0, sclk_edge_cyc = 0;
    int  falls[$];
    bit  prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0, last_dummy = 1'b0;
    bit [9:0] prev_code;
    bit  prev_dum;

    always @(negedge clk) if (!rst) begin
        cyc++;
        if (prev_cs && !adc_cs_n_o) begin
            if (nframes > 0) begin
                chk(hi_cnt >= QUIET, "R6", "quiet gap", hi_cnt, QUIET);
                if (last_dummy) chk(hi_cnt >= PWRUP, "R10", "wake gap", hi_cnt, PWRUP);
            end
            fall_cyc = cyc;
            falls.push_back(cyc);
            nfalls++;
            rises = 0;
        end
        if (adc_cs_n_o) hi_cnt++; else hi_cnt = 0;
        if (!adc_cs_n_o && prev_sclk && !adc_sclk_o) begin
            if (rises == 0) chk(cyc - fall_cyc == HALF, "R2", "setup to first fall", cyc - fall_cyc, HALF);
            else chk(cyc - sclk_edge_cyc == HALF, "R3", "high phase", cyc - sclk_edge_cyc, HALF);
            sclk_edge_cyc = cyc;
        end
        if (!adc_cs_n_o && !prev_sclk && adc_sclk_o) begin
            chk(cyc - sclk_edge_cyc == HALF, "R3", "low phase", cyc - sclk_edge_cyc, HALF);
            sclk_edge_cyc = cyc;
            rises++;
        end
        if (!prev_cs && adc_cs_n_o) begin
            chk(rises == 16, "R2", "rising edges per frame", rises, 16);
            chk(adc_sclk_o == 1'b1, "R2", "sclk high at frame end", adc_sclk_o, 1);
            chk(valid_o == 1'b1, "R5", "valid with cs rise", valid_o, 1);
            nframes++;
        end
        if (prev_valid) begin
            chk(valid_o == 1'b0, "R5", "valid width", valid_o, 0);
            chk(code_o == prev_code && dummy_o == prev_dum, "R5", "result held", code_o, prev_code);
        end
        if (valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected result", code_o, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(code_o == e.code, "R4", "code", code_o, e.code);
                chk(dummy_o == e.dum, "R10", "dummy flag", dummy_o, e.dum);
                last_dummy = e.dum;
            end
            prev_code = code_o;
            prev_dum = dummy_o;
        end
        prev_cs = adc_cs_n_o;
        prev_sclk = adc_sclk_o;
        prev_valid = valid_o;
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(adc_cs_n_o == 1'b1, "R1", "cs after reset", adc_cs_n_o, 1);
        chk(adc_sclk_o == 1'b1, "R1", "sclk after reset", adc_sclk_o, 1);
        chk(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);

        // R4: single frame, mixed bit pattern
        load(10'h2A5, 1'b0);
        pulse_start();
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);

        // R7: extra starts during a frame collapse into one held request
        n0 = nframes;
        load(10'h3FF, 1'b0);
        load(10'h000, 1'b0);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (1500) @(negedge clk);
        chk(nframes - n0 == 2, "R7", "frames from held starts", nframes - n0, 2);

        // R8: periodic timer spacing
        load(10'h155, 1'b0);
        load(10'h0AA, 1'b0);
        load(10'h001, 1'b0);
        n0 = nfalls;
        period_i = 16'd600;
        timer_en_i = 1'b1;
        wait (nfalls == n0 + 3);
        @(negedge clk) timer_en_i = 1'b0;
        chk(falls[n0+1] - falls[n0] == 600, "R8", "timer interval 1", falls[n0+1] - falls[n0], 600);
        chk(falls[n0+2] - falls[n0+1] == 600, "R8", "timer interval 2", falls[n0+2] - falls[n0+1], 600);
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);

        // R9: power-save drops starts and ticks
        n0 = nfalls;
        psave_i = 1'b1;
        repeat (5) @(negedge clk);
        pulse_start();
        period_i = 16'd100;
        timer_en_i = 1'b1;
        repeat (400) @(negedge clk);
        timer_en_i = 1'b0;
        chk(nfalls == n0, "R9", "no frame in power-save", nfalls - n0, 0);
        chk(adc_cs_n_o == 1'b1, "R9", "cs high in power-save", adc_cs_n_o, 1);
        psave_i = 1'b0;
        repeat (400) @(negedge clk);
        chk(nfalls == n0, "R9", "dropped request not replayed", nfalls - n0, 0);

        // R10: first frame after wake is a dummy, next waits the power-up gap
        load(10'h123, 1'b1);
        load(10'h2F0, 1'b0);
        n0 = nfalls;
        pulse_start();
        wait (nfalls == n0 + 1);
        pulse_start();
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);
        chk(nfalls == n0 + 2, "R10", "frames after wake", nfalls - n0, 2);

        finish_run();
    end

endmodule